// File: doc/BRIEF.md
# Same-Line Store Commit Coalescer

This block is the commit stage between the oldest entries of a store buffer and the single write port of a data cache. Each cycle it looks at a small window of the oldest entries. It starts at the head and collects the longest unbroken run of entries that are valid, have retired and address the same cache line. It stops at the first entry that breaks the run. The bytes of every store in the run are merged into one line-wide write with a per-byte mask. Where two stores in the run write the same byte, the younger store's byte is kept.

The merged write goes to the cache as one request, so a whole run of stores uses one port cycle. When the cache accepts the write, the block reports how many head entries the store buffer must free. Entries are always freed from the head, in order, so the buffer stays a plain ring. Because only a contiguous run at the head is merged, stores still become visible in program order.

Each entry carries a line address, a word index, a data word and byte enables. The word index selects which word of the line the entry writes. The block is purely combinational from the window to the write request. The clock and reset serve only the embedded checks.

Top module: `store_line_merger`

## Requirements
- R1: `wr_valid` is 1 exactly when entry 0 of the window is both valid and retired. When `wr_valid` is 0, `head_pop` is 0.
- R2: An entry joins the group only if every entry in front of it joined. It must also be valid and retired. The first entry that is not valid, or not retired, closes the group, and later entries stay out even if they qualify.
- R3: An entry whose line address differs from entry 0 closes the group. A later entry to entry 0's line is not merged across it.
- R4: Entry i writes word `head_word[i]` of the line. Byte enable bit k of entry i maps to line byte `8*head_word[i]+k`, and data byte k (bits 8k+7..8k) maps to the same line byte. Stores to the first byte (0) and the last byte (63) of one line merge into one write.
- R5: When stores in the group write the same line byte, `wr_data` holds the byte of the youngest of them, meaning the highest window index.
- R6: A group holds at most DEPTH entries. When all DEPTH entries qualify, all of them are merged.
- R7: `head_pop` equals the number of entries in the group when `wr_valid` and `wr_ready` are both 1. Otherwise it is 0.
- R8: `wr_mask` is the OR of the mapped byte enables of the group's entries. Every `wr_data` byte whose mask bit is 0 reads 0.
- R9: When `wr_valid` is 1, `wr_line` equals the line address of entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| head_valid | input | DEPTH | Entry i holds a store (index 0 is oldest) |
| head_retired | input | DEPTH | Entry i has retired |
| head_line | input | DEPTH*LINE_AW | Line address of each entry |
| head_word | input | DEPTH*3 | Word index within the line of each entry |
| head_data | input | DEPTH*64 | Data word of each entry |
| head_be | input | DEPTH*8 | Byte enables of each entry |
| wr_ready | input | 1 | Cache accepts the write this cycle |
| wr_valid | output | 1 | A merged write is offered |
| wr_line | output | LINE_AW | Line address of the write |
| wr_data | output | 512 | Merged line data |
| wr_mask | output | 64 | Merged byte mask |
| head_pop | output | 3 | Entries to free from the head this cycle |

## Verification
A group boundary that is wrong shows up the same cycle in two ways. `head_pop` gives the wrong count, and `wr_mask` gains bytes from an entry that should have been left out, or loses bytes from one that belonged. A wrong merge order shows as a stale byte in `wr_data` wherever stores overlap. Stale bytes outside the mask show as nonzero data next to a cleared mask bit. Since there is no internal state, every such defect is visible in the very cycle the window is presented.

// File: rtl/store_line_merger.sv
module store_line_merger #(
  parameter int DEPTH      = 4,
  parameter int LINE_AW    = 26,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              head_valid,
  input  logic [DEPTH-1:0]              head_retired,
  input  logic [DEPTH*LINE_AW-1:0]      head_line,
  input  logic [DEPTH*$clog2(LINE_BYTES/WORD_BYTES)-1:0] head_word,
  input  logic [DEPTH*WORD_BYTES*8-1:0] head_data,
  input  logic [DEPTH*WORD_BYTES-1:0]   head_be,
  input  logic                          wr_ready,
  output logic                          wr_valid,
  output logic [LINE_AW-1:0]            wr_line,
  output logic [LINE_BYTES*8-1:0]       wr_data,
  output logic [LINE_BYTES-1:0]         wr_mask,
  output logic [$clog2(DEPTH+1)-1:0]    head_pop
);
  localparam int LW  = LINE_BYTES * 8;
  localparam int WW  = WORD_BYTES * 8;
  localparam int WIW = $clog2(LINE_BYTES / WORD_BYTES);
  localparam int CW  = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]      take;
  logic [LW-1:0]         ent_d [DEPTH];
  logic [LINE_BYTES-1:0] ent_m [DEPTH];
  logic [LW-1:0]         ent_bm[DEPTH];
  logic [CW-1:0]         cnt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign ent_d[i] = LW'(head_data[i*WW +: WW]) << (head_word[i*WIW +: WIW] * WW);
    assign ent_m[i] = LINE_BYTES'(head_be[i*WORD_BYTES +: WORD_BYTES])
                      << (head_word[i*WIW +: WIW] * WORD_BYTES);
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
      assign ent_bm[i][b*8 +: 8] = {8{ent_m[i][b]}};
    end
  end

  always_comb begin
    take[0] = head_valid[0] & head_retired[0];
    for (int i = 1; i < DEPTH; i++)
      take[i] = take[i-1] & head_valid[i] & head_retired[i] &
                (head_line[i*LINE_AW +: LINE_AW] == head_line[0 +: LINE_AW]);
  end

  always_comb begin
    wr_data = '0;
    wr_mask = '0;
    cnt     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (take[i]) begin
        wr_data = (wr_data & ~ent_bm[i]) | (ent_d[i] & ent_bm[i]);
        wr_mask = wr_mask | ent_m[i];
        cnt     = cnt + CW'(1);
      end
    end
  end

  assign wr_valid = take[0];
  assign wr_line  = head_line[0 +: LINE_AW];
  assign head_pop = (wr_valid && wr_ready) ? cnt : '0;

  assert_pop_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    head_pop <= CW'(DEPTH));
  assert_pop_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (head_pop != '0) |-> (wr_valid && wr_ready));
  assert_line_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_line == head_line[0 +: LINE_AW]));

  for (genvar i = 0; i < DEPTH; i++) begin : g_chk
    assert_popped_retired_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (head_pop > CW'(i)) |-> (head_valid[i] && head_retired[i]));
    assert_popped_same_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (head_pop > CW'(i)) |-> (head_line[i*LINE_AW +: LINE_AW] == wr_line));
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_zchk
    assert_unmasked_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask[b] |-> (wr_data[b*8 +: 8] == 8'h00));
  end
endmodule

// File: tb/sim_store_line_merger.sv
module sim_store_line_merger;
  localparam int PERIOD = 10;
  localparam int N  = 4;
  localparam int LA = 26;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] hv, hr;
  logic [N*LA-1:0] hl;
  logic [N*3-1:0] hw;
  logic [N*64-1:0] hd;
  logic [N*8-1:0] hb;
  logic rdy;
  logic wv;
  logic [LA-1:0] wl;
  logic [511:0] wd;
  logic [63:0] wm;
  logic [2:0] pop;

  int tests = 0, fails = 0;

  logic [LA-1:0] e_line[N];
  logic [2:0]    e_word[N];
  logic [63:0]   e_data[N];
  logic [7:0]    e_be[N];

  store_line_merger #(.DEPTH(N), .LINE_AW(LA)) u0 (
    .clk(clk), .rst_n(rst_n), .head_valid(hv), .head_retired(hr),
    .head_line(hl), .head_word(hw), .head_data(hd), .head_be(hb),
    .wr_ready(rdy), .wr_valid(wv), .wr_line(wl), .wr_data(wd),
    .wr_mask(wm), .head_pop(pop));

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(string tag);
    int cnt;
    bit stop;
    logic [511:0] ed;
    logic [63:0] em;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      hl[i*LA +: LA] = e_line[i];
      hw[i*3 +: 3]   = e_word[i];
      hd[i*64 +: 64] = e_data[i];
      hb[i*8 +: 8]   = e_be[i];
    end
    cnt = 0; stop = 0; ed = '0; em = '0;
    for (int i = 0; i < N; i++) begin
      if (!stop && hv[i] && hr[i] && (i == 0 || e_line[i] == e_line[0])) begin
        cnt++;
        for (int k = 0; k < 8; k++) begin
          if (e_be[i][k]) begin
            em[e_word[i]*8 + k] = 1'b1;
            ed[(e_word[i]*8 + k)*8 +: 8] = e_data[i][k*8 +: 8];
          end
        end
      end else stop = 1;
    end
    #1;
    chk({tag, " R1 wr_valid"}, 512'(wv), 512'(cnt != 0));
    chk({tag, " R2 R3 R6 R7 head_pop"}, 512'(pop), 512'((rdy && cnt != 0) ? cnt : 0));
    chk({tag, " R4 R8 wr_mask"}, 512'(wm), 512'(em));
    chk({tag, " R5 R8 wr_data"}, wd, ed);
    if (cnt != 0) chk({tag, " R9 wr_line"}, 512'(wl), 512'(e_line[0]));
  endtask

  task automatic clear_window();
    hv = '0; hr = '0;
    for (int i = 0; i < N; i++) begin
      e_line[i] = '0; e_word[i] = '0; e_data[i] = '0; e_be[i] = '0;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rdy = 1;
    clear_window();
    hl = '0; hw = '0; hd = '0; hb = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("reset R1 wr_valid", 512'(wv), 512'(0));
    chk("reset R7 head_pop", 512'(pop), 512'(0));
    rst_n = 1;

    // R4: first and last byte of one line
    clear_window();
    hv = 4'b0011; hr = 4'b0011;
    e_line[0] = 26'h12345; e_word[0] = 0; e_be[0] = 8'h01; e_data[0] = 64'hAA;
    e_line[1] = 26'h12345; e_word[1] = 7; e_be[1] = 8'h80; e_data[1] = 64'hBB00_0000_0000_0000;
    apply_and_check("first-last");

    // R5: overlap, youngest wins
    clear_window();
    hv = 4'b0111; hr = 4'b0111;
    for (int i = 0; i < 3; i++) begin
      e_line[i] = 26'h7; e_word[i] = 3; e_be[i] = 8'hFF;
      e_data[i] = {8{8'(8'h10 + i)}};
    end
    e_be[2] = 8'h0F;
    apply_and_check("overlap");

    // R3: different line breaks the run
    clear_window();
    hv = 4'b1111; hr = 4'b1111;
    e_line[0] = 26'h5; e_line[1] = 26'h6; e_line[2] = 26'h5; e_line[3] = 26'h5;
    for (int i = 0; i < N; i++) begin e_word[i] = 3'(i); e_be[i] = 8'hFF; e_data[i] = 64'(i + 1); end
    apply_and_check("line-break");

    // R2: non-retired entry closes the group
    hr = 4'b1101;
    for (int i = 0; i < N; i++) e_line[i] = 26'h5;
    apply_and_check("not-retired");

    // R6: full window merged
    hr = 4'b1111;
    apply_and_check("full");

    // R7: not accepted
    rdy = 0;
    apply_and_check("not-ready");
    rdy = 1;

    // R1: head not retired
    hr = 4'b1110;
    apply_and_check("head-pending");

    for (int t = 0; t < 400; t++) begin
      hv = 4'($urandom); hr = 4'($urandom | $urandom);
      rdy = ($urandom % 4) != 0;
      for (int i = 0; i < N; i++) begin
        e_line[i] = 26'($urandom % 2);
        e_word[i] = 3'($urandom);
        e_be[i]   = 8'($urandom);
        e_data[i] = {$urandom, $urandom};
      end
      apply_and_check("random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule